// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block carries data words from one clock domain into a second, unrelated clock domain. A producer in the write domain presents a word with a write enable and watches a full flag. A consumer in the read domain watches an empty flag and takes words with a read enable. The oldest stored word is always visible on the read data output, so the consumer can inspect it before it decides to take it.

Each side keeps its own binary position counter, one bit wider than the storage address. The extra bit separates a counter that has wrapped from one that has not. Only a Gray-coded copy of each counter crosses to the other side, through two flops owned by the receiving clock. Because that copy always lags, the flags err on the safe side. Full may stay set after room has appeared, and empty may stay set after a word has landed. Neither flag ever reports room or data that is not there. Depth is a power of two, and data width and address width are parameters.

Top module: `afifo_gray`

## Requirements
- R1: While a side's reset is low at a clock edge, that side's counter clears to zero. After the edge, `rd_empty` reads 1 and `wr_full` reads 0.
- R2: Words leave in the order they were accepted. Whenever `rd_empty` is 0, `rd_data` already shows the oldest stored word and holds it until a read is accepted.
- R3: After 2^ADDR_W accepted writes with no reads, `wr_full` reads 1 after the clock edge that accepted the last of those writes.
- R4: A write presented while `wr_full` is 1 is dropped. No counter moves and no stored word changes.
- R5: A read presented while `rd_empty` is 1 is dropped, and the read counter does not move.
- R6: After a write into an empty FIFO, `rd_empty` falls within 5 read-clock cycles.
- R7: After a read from a full FIFO, `wr_full` falls within 5 write-clock cycles.
- R8: `wr_full` is 0 only when fewer than 2^ADDR_W words are stored, and `rd_empty` is 0 only when at least one word is stored.
- R9: The Gray copy of each counter changes in at most one bit per clock of its own domain.
- R10: Order and flag behaviour hold while both counters wrap through the storage many times under concurrent traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain synchronous reset, active low |
| wr_en | input | 1 | Request to store `wr_data` |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No room; writes are dropped |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain synchronous reset, active low |
| rd_en | input | 1 | Take the word shown on `rd_data` |
| rd_data | output | DATA_W | Oldest stored word, shown without a strobe |
| rd_empty | output | 1 | Nothing stored; reads are dropped |

## Verification
A counter that slips or steps twice shows up at the read port as a wrong or repeated word. It is seen on the first read of the affected slot, at most one pass of the storage later. A wrong full comparison either lets a ninth word overwrite the oldest one, which is caught when that slot drains, or keeps full set too long, which is caught within five write cycles of a read. A broken crossing path delays or skips a flag change. That breaks the five-cycle bounds on the first flag change after the fault.

// File: rtl/afifo_pkg.sv
`timescale 1ns/1ps
// Package afifo_pkg
// Helpers shared by the FIFO pointer logic. Counters are at most 32 bits wide.
package afifo_pkg;

    // Convert a binary count to its reflected Gray code.
    function automatic logic [31:0] gray_of(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/afifo_sync2.sv
`timescale 1ns/1ps
// Module afifo_sync2
// Two-flop synchroniser for a Gray-coded pointer entering this clock domain.
// Assumes the source changes at most one bit per source clock and is registered.
module afifo_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two capture stages; the first may go metastable, the second settles it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/afifo_mem.sv
`timescale 1ns/1ps
// Module afifo_mem
// Storage array: written on the write clock, read combinationally by address.
// Assumes the caller only enables writes into slots that are free.
module afifo_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Store one word per accepted write.
    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Present the slot under the read pointer with no strobe.
    assign rdata = cells[raddr];
endmodule

// File: rtl/afifo_wptr.sv
`timescale 1ns/1ps
// Module afifo_wptr
// Write-side counter with full detection against a synchronised read pointer.
// Assumes ADDR_W >= 2. Full is registered and computed from the next pointer.
module afifo_wptr
    import afifo_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W:0]     rq_gray,
    output logic [ADDR_W-1:0]   waddr,
    output logic [ADDR_W:0]     wgray,
    output logic                full,
    output logic                wr_go
);
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0] wbin, wbin_nx, wgray_nx;
    logic [31:0]      g32;
    logic             full_nx;

    assign wr_go = wr_en & ~full;
    assign waddr = wbin[ADDR_W-1:0];

    // Next pointer and full test: top two Gray bits inverted, rest equal.
    always_comb begin
        wbin_nx  = wbin + PTR_W'(wr_go);
        g32      = gray_of(32'(wbin_nx));
        wgray_nx = g32[PTR_W-1:0];
        full_nx  = (wgray_nx == {~rq_gray[PTR_W-1:PTR_W-2], rq_gray[PTR_W-3:0]});
    end

    // Pointer, its Gray copy and the full flag, all in the write domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
            full  <= 1'b0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wgray_nx;
            full  <= full_nx;
        end
    end

    a_r1_full_low_after_reset: assert property (@(posedge clk)
        !rst_n |=> !full);

    a_r4_write_dropped_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en) |=> (wbin == $past(wbin)));

    a_r9_wgray_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(wgray ^ $past(wgray)) <= 1));
endmodule

// File: rtl/afifo_rptr.sv
`timescale 1ns/1ps
// Module afifo_rptr
// Read-side counter with empty detection against a synchronised write pointer.
// Empty is registered and computed from the next pointer.
module afifo_rptr
    import afifo_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [ADDR_W:0]     wq_gray,
    output logic [ADDR_W-1:0]   raddr,
    output logic [ADDR_W:0]     rgray,
    output logic                empty
);
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0] rbin, rbin_nx, rgray_nx;
    logic [31:0]      g32;
    logic             rd_go;

    assign rd_go = rd_en & ~empty;
    assign raddr = rbin[ADDR_W-1:0];

    // Next pointer and empty test: Gray pointers equal in every bit.
    always_comb begin
        rbin_nx  = rbin + PTR_W'(rd_go);
        g32      = gray_of(32'(rbin_nx));
        rgray_nx = g32[PTR_W-1:0];
    end

    // Pointer, its Gray copy and the empty flag, all in the read domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
            empty <= 1'b1;
        end else begin
            rbin  <= rbin_nx;
            rgray <= rgray_nx;
            empty <= (rgray_nx == wq_gray);
        end
    end

    a_r1_empty_high_after_reset: assert property (@(posedge clk)
        !rst_n |=> empty);

    a_r5_read_dropped_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en) |=> (rbin == $past(rbin)));

    a_r9_rgray_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(rgray ^ $past(rgray)) <= 1));
endmodule

// File: rtl/afifo_gray.sv
`timescale 1ns/1ps
// Module afifo_gray
// Dual-clock FIFO with first-word fall-through reads and pessimistic flags.
// Assumes the two clocks are unrelated and each reset is held for at least
// three cycles of its own clock.
module afifo_gray #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty
);
    localparam int PTR_W = ADDR_W + 1;

    logic [ADDR_W-1:0] waddr, raddr;
    logic [PTR_W-1:0]  wgray, rgray, wgray_in_rd, rgray_in_wr;
    logic              wr_go;

    afifo_wptr #(.ADDR_W(ADDR_W)) u_wptr (
        .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .rq_gray(rgray_in_wr),
        .waddr(waddr), .wgray(wgray), .full(wr_full), .wr_go(wr_go)
    );

    afifo_rptr #(.ADDR_W(ADDR_W)) u_rptr (
        .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .wq_gray(wgray_in_rd),
        .raddr(raddr), .rgray(rgray), .empty(rd_empty)
    );

    afifo_sync2 #(.W(PTR_W)) u_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_in_rd)
    );

    afifo_sync2 #(.W(PTR_W)) u_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_in_wr)
    );

    afifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wclk(wr_clk), .we(wr_go), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(rd_data)
    );
endmodule

// File: tb/sim_afifo_gray.sv
`timescale 1ns/1ps
module sim_afifo_gray;
    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          wr_full, rd_empty;

    always #2 wr_clk = ~wr_clk;   // 250 MHz
    always #3 rd_clk = ~rd_clk;

    afifo_gray #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
        .rd_data(rd_data), .rd_empty(rd_empty)
    );

    int            nchk = 0, nfail = 0;
    int            wi = 0, ri = 0;
    logic [DW-1:0] log_q [256];
    bit            done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    // Accept-checked write; R8: full low implies room in the model.
    task automatic push(input logic [DW-1:0] d);
        @(negedge wr_clk);
        while (wr_full) @(negedge wr_clk);
        chk((wi - ri) < DEPTH, "R8 full low with no room", wi - ri, DEPTH - 1);
        wr_en = 1'b1; wr_data = d; log_q[wi % 256] = d; wi++;
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    // Read with order check; R8: empty low implies data in the model.
    task automatic pop();
        @(negedge rd_clk);
        while (rd_empty) @(negedge rd_clk);
        chk(wi > ri, "R8 empty low with no data", wi - ri, 1);
        chk(rd_data == log_q[ri % 256], "R2 order", int'(rd_data), int'(log_q[ri % 256]));
        rd_en = 1'b1; ri++;
        @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        repeat (5) @(negedge rd_clk);
        chk(rd_empty == 1'b1, "R1 empty in reset", rd_empty, 1);
        chk(wr_full == 1'b0, "R1 full in reset", wr_full, 0);
        @(negedge wr_clk) wr_rst_n = 1'b1;
        @(negedge rd_clk) rd_rst_n = 1'b1;
        repeat (3) @(negedge rd_clk);
        chk(rd_empty == 1'b1, "R1 empty after reset", rd_empty, 1);
        chk(wr_full == 1'b0, "R1 full after reset", wr_full, 0);
    endtask

    task automatic t_fall_through();
        int n = 0;
        push(8'h5A);
        while (rd_empty && n < 20) begin @(negedge rd_clk); n++; end
        chk(!rd_empty && n <= 5, "R6 empty release latency", n, 5);
        repeat (3) begin
            @(negedge rd_clk);
            chk(rd_data == 8'h5A && !rd_empty, "R2 word shown without strobe", int'(rd_data), 'h5A);
        end
        pop();
    endtask

    task automatic t_fill_and_block();
        int n = 0;
        for (int i = 0; i < DEPTH; i++) push(DW'(i + 16));
        chk(wr_full == 1'b1, "R3 full after depth writes", wr_full, 1);
        repeat (3) begin
            @(negedge wr_clk);
            wr_en = 1'b1; wr_data = 8'hEE;
            chk(wr_full == 1'b1, "R4 full held under blocked write", wr_full, 1);
        end
        @(negedge wr_clk) wr_en = 1'b0;
        pop();
        while (wr_full && n < 20) begin @(negedge wr_clk); n++; end
        chk(!wr_full && n <= 5, "R7 full release latency", n, 5);
        for (int i = 1; i < DEPTH; i++) pop();
        repeat (10) @(negedge rd_clk);
        chk(rd_empty == 1'b1, "R4 blocked word not stored", rd_empty, 1);
    endtask

    task automatic t_read_empty();
        repeat (3) begin
            @(negedge rd_clk);
            rd_en = 1'b1;
            chk(rd_empty == 1'b1, "R5 empty held under blocked read", rd_empty, 1);
        end
        @(negedge rd_clk) rd_en = 1'b0;
        push(8'hA1); push(8'hA2);
        pop(); pop();   // R5: wrong data here would mean the read pointer moved
        repeat (10) @(negedge rd_clk);
        chk(rd_empty == 1'b1, "R5 empty after draining", rd_empty, 1);
    endtask

    task automatic t_wrap();
        fork
            for (int i = 0; i < 3 * DEPTH + 3; i++) push(DW'(i * 7 + 3));
            for (int i = 0; i < 3 * DEPTH + 3; i++) pop();
        join
        repeat (10) @(negedge rd_clk);
        chk(ri == wi && rd_empty, "R10 all words through after wrap", ri, wi);
        chk(!wr_full, "R10 full clear after wrap", wr_full, 0);
    endtask

    initial begin
        t_reset();
        t_fall_through();
        t_fill_and_block();
        t_read_empty();
        t_wrap();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule